// File: doc/BRIEF.md
# Two-Class Prioritized Interrupt Controller

This block gathers fifteen interrupt lines, numbered 1 through 15, for a single processor. It presents them as one 4-bit request number with a valid flag, and it accepts an acknowledge that names the serviced line. Each line can be latched into a pending set or, when its broadcast bit is set, into a force set. Software can also set, clear or replace bits in the force set directly. A per-line mask gates both sets.

A per-line level bit places every unmasked request in a high class or a low class. The high class always wins. Inside the winning class, the highest-numbered line is presented. All state is reached over a plain 32-bit register bus with an 8-bit byte offset. Writes take effect at the clock edge. Reads are combinational from the stored state.

Top module: `pirq_ctrl`

## Requirements
- R1: After reset every register reads zero, and `irq_valid` is 0 with `irq_req` equal to 0.
- R2: Bit 0 of the level (offset 0x00), broadcast (0x14) and mask (0x40) registers is never stored. Only write bits 15:1 are kept, and bits 31:16 read back as zero.
- R3: An input line k (1..15) that is high at a clock edge sets pending bit k when broadcast bit k is 0, and sets force bit k instead when broadcast bit k is 1. A high level on input bit 0 has no effect.
- R4: A write to offset 0x0C clears every pending bit k (k ≥ 1) whose write-data bit k is 1. A read of 0x0C returns zero.
- R5: A write to offset 0x80 gives force = (force OR wdata[15:1]) AND NOT wdata[31:17], bit-aligned. A bit named in both halves ends cleared.
- R6: A write to offset 0x08 replaces the force register with wdata[15:1]. Reads at 0x08 and 0x80 both return the force register.
- R7: The effective request vector is (pending OR force) AND mask. When it is zero, `irq_valid` is 0 and `irq_req` is 0.
- R8: If any effective request has its level bit at 1, `irq_req` is the highest such line number. Otherwise it is the highest effective line number. `irq_valid` is 1 exactly when `irq_req` is nonzero.
- R9: `ack_valid` with `ack_num` = k (1..15) clears bit k of both pending and force at the clock edge. `ack_num` = 0 changes nothing.
- R10: When an input sets bit k in the same cycle that an acknowledge or a clear write removes bit k, the bit ends set.
- R11: Offset 0x10 always reads zero and ignores writes. Offset 0xC0 stores only write bits 3:0 and reads them back zero-extended.
- R12: Offsets that are not word-aligned, and offsets outside the map (including 0x44..0x7C, 0x84..0xBC and 0xC4..0xFC), read zero. Writes to them change no register.
- R13: A write, input or acknowledge at clock edge n is visible on `bus_rdata`, `irq_req` and `irq_valid` after edge n, with no further latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | 16 | Interrupt lines; bit k is line k, bit 0 unused |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset within the register window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the offset |
| ack_valid | input | 1 | Acknowledge strobe |
| ack_num | input | 4 | Line number being acknowledged |
| irq_req | output | 4 | Selected line number, 0 when none |
| irq_valid | output | 1 | A request is presented |

## Verification
Each stored state changes at exactly one clock edge. After that edge, the request outputs and read data follow the new state combinationally, so every result is due in the same half-cycle that follows the edge. The bench drives all stimulus at the falling edge and lets the reference model absorb it just after the rising edge. It compares `irq_req`, `irq_valid` and `bus_rdata` at the next falling edge, with a read offset applied 1 ns before sampling. Same-edge collisions of input, acknowledge and clear are resolved in the model by the set-wins rule, so the model itself fixes which edge each bit should change on.

// File: rtl/pirq_pkg.sv
package pirq_pkg;

  localparam int ADDR_W = 8;

  localparam logic [ADDR_W-1:0] OFF_LEVEL  = 8'h00;
  localparam logic [ADDR_W-1:0] OFF_PEND   = 8'h04;
  localparam logic [ADDR_W-1:0] OFF_FALIAS = 8'h08;
  localparam logic [ADDR_W-1:0] OFF_CLEAR  = 8'h0C;
  localparam logic [ADDR_W-1:0] OFF_MPSTAT = 8'h10;
  localparam logic [ADDR_W-1:0] OFF_BCAST  = 8'h14;
  localparam logic [ADDR_W-1:0] OFF_MASK   = 8'h40;
  localparam logic [ADDR_W-1:0] OFF_FORCE  = 8'h80;
  localparam logic [ADDR_W-1:0] OFF_EXT    = 8'hC0;

  typedef enum logic [3:0] {
    SEL_NONE,
    SEL_LEVEL,
    SEL_PEND,
    SEL_FALIAS,
    SEL_CLEAR,
    SEL_MPSTAT,
    SEL_BCAST,
    SEL_MASK,
    SEL_FORCE,
    SEL_EXT
  } reg_sel_e;

endpackage

// File: rtl/pirq_decode.sv
module pirq_decode
  import pirq_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  output reg_sel_e          sel
);

  always_comb begin
    sel = SEL_NONE;
    if (addr[1:0] == 2'b00) begin
      case (addr)
        OFF_LEVEL:  sel = SEL_LEVEL;
        OFF_PEND:   sel = SEL_PEND;
        OFF_FALIAS: sel = SEL_FALIAS;
        OFF_CLEAR:  sel = SEL_CLEAR;
        OFF_MPSTAT: sel = SEL_MPSTAT;
        OFF_BCAST:  sel = SEL_BCAST;
        OFF_MASK:   sel = SEL_MASK;
        OFF_FORCE:  sel = SEL_FORCE;
        OFF_EXT:    sel = SEL_EXT;
        default:    sel = SEL_NONE;
      endcase
    end
  end

endmodule

// File: rtl/pirq_regfile.sv
module pirq_regfile
  import pirq_pkg::*;
#(
  parameter int NLINES = 16,
  parameter int DATA_W = 32,
  parameter int EXT_W  = 4,
  localparam int ID_W  = $clog2(NLINES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NLINES-1:0] irq_in,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  reg_sel_e          sel,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              ack_valid,
  input  logic [ID_W-1:0]   ack_num,
  output logic [NLINES-1:0] level_q,
  output logic [NLINES-1:0] pend_q,
  output logic [NLINES-1:0] force_q,
  output logic [NLINES-1:0] bcast_q,
  output logic [NLINES-1:0] mask_q,
  output logic [EXT_W-1:0]  ext_q,
  output logic [NLINES-1:0] in_pend_set,
  output logic [NLINES-1:0] in_force_set,
  output logic [NLINES-1:0] ack_vec
);

  localparam logic [NLINES-1:0] KEEP = {{(NLINES-1){1'b1}}, 1'b0};

  function automatic logic [NLINES-1:0] line_bit(input logic [ID_W-1:0] k);
    logic [NLINES-1:0] r;
    r    = '0;
    r[k] = 1'b1;
    return r & KEEP;
  endfunction

  function automatic logic [NLINES-1:0] force_update(
    input logic [NLINES-1:0] old,
    input logic [NLINES-1:0] setv,
    input logic [NLINES-1:0] clrv
  );
    return (old | setv) & ~clrv;
  endfunction

  logic              wr_any;
  logic [NLINES-1:0] wd_lo, wd_hi;
  logic [NLINES-1:0] clr_vec;
  logic [NLINES-1:0] force_base;
  logic [NLINES-1:0] pend_nx, force_nx;

  assign wr_any = bus_sel & bus_wr;
  assign wd_lo  = bus_wdata[NLINES-1:0] & KEEP;
  assign wd_hi  = bus_wdata[2*NLINES-1:NLINES] & KEEP;

  assign in_pend_set  = irq_in & ~bcast_q & KEEP;
  assign in_force_set = irq_in &  bcast_q & KEEP;
  assign ack_vec      = ack_valid ? line_bit(ack_num) : '0;
  assign clr_vec      = (wr_any && sel == SEL_CLEAR) ? wd_lo : '0;

  always_comb begin
    force_base = force_q;
    if (wr_any && sel == SEL_FALIAS)
      force_base = wd_lo;
    else if (wr_any && sel == SEL_FORCE)
      force_base = force_update(force_q, wd_lo, wd_hi);
  end

  assign pend_nx  = (pend_q & ~clr_vec & ~ack_vec) | in_pend_set;
  assign force_nx = (force_base & ~ack_vec) | in_force_set;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      level_q <= '0;
      pend_q  <= '0;
      force_q <= '0;
      bcast_q <= '0;
      mask_q  <= '0;
      ext_q   <= '0;
    end else begin
      pend_q  <= pend_nx;
      force_q <= force_nx;
      if (wr_any && sel == SEL_LEVEL) level_q <= wd_lo;
      if (wr_any && sel == SEL_BCAST) bcast_q <= wd_lo;
      if (wr_any && sel == SEL_MASK)  mask_q  <= wd_lo;
      if (wr_any && sel == SEL_EXT)   ext_q   <= bus_wdata[EXT_W-1:0];
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (sel)
      SEL_LEVEL:  bus_rdata[NLINES-1:0] = level_q;
      SEL_PEND:   bus_rdata[NLINES-1:0] = pend_q;
      SEL_FALIAS: bus_rdata[NLINES-1:0] = force_q;
      SEL_FORCE:  bus_rdata[NLINES-1:0] = force_q;
      SEL_BCAST:  bus_rdata[NLINES-1:0] = bcast_q;
      SEL_MASK:   bus_rdata[NLINES-1:0] = mask_q;
      SEL_EXT:    bus_rdata[EXT_W-1:0]  = ext_q;
      default:    bus_rdata = '0;
    endcase
  end

endmodule

// File: rtl/pirq_select.sv
module pirq_select #(
  parameter int NLINES = 16,
  localparam int ID_W  = $clog2(NLINES)
) (
  input  logic [NLINES-1:0] pend_q,
  input  logic [NLINES-1:0] force_q,
  input  logic [NLINES-1:0] mask_q,
  input  logic [NLINES-1:0] level_q,
  output logic [NLINES-1:0] eff_vec,
  output logic              hi_any,
  output logic [ID_W-1:0]   irq_req,
  output logic              irq_valid
);

  function automatic logic [ID_W-1:0] top_index(input logic [NLINES-1:0] v);
    logic [ID_W-1:0] r;
    r = '0;
    for (int i = 1; i < NLINES; i++)
      if (v[i]) r = ID_W'(i);
    return r;
  endfunction

  logic [NLINES-1:0] hi_vec, lo_vec, win_vec;

  assign eff_vec = (pend_q | force_q) & mask_q;
  assign hi_vec  = eff_vec & level_q;
  assign lo_vec  = eff_vec & ~level_q;
  assign hi_any  = |hi_vec;
  assign win_vec = hi_any ? hi_vec : lo_vec;

  assign irq_req   = top_index(win_vec);
  assign irq_valid = (irq_req != '0);

endmodule

// File: rtl/pirq_ctrl.sv
module pirq_ctrl
  import pirq_pkg::*;
#(
  parameter int NLINES = 16,
  parameter int DATA_W = 32,
  parameter int EXT_W  = 4,
  localparam int ID_W  = $clog2(NLINES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NLINES-1:0] irq_in,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              ack_valid,
  input  logic [ID_W-1:0]   ack_num,
  output logic [ID_W-1:0]   irq_req,
  output logic              irq_valid
);

  reg_sel_e          sel;
  logic [NLINES-1:0] level_q, pend_q, force_q, bcast_q, mask_q;
  logic [EXT_W-1:0]  ext_q;
  logic [NLINES-1:0] in_pend_set, in_force_set, ack_vec;
  logic [NLINES-1:0] eff_vec;
  logic              hi_any;

  pirq_decode u_decode (
    .addr (bus_addr),
    .sel  (sel)
  );

  pirq_regfile #(
    .NLINES (NLINES),
    .DATA_W (DATA_W),
    .EXT_W  (EXT_W)
  ) u_regs (
    .clk          (clk),
    .rst_n        (rst_n),
    .irq_in       (irq_in),
    .bus_sel      (bus_sel),
    .bus_wr       (bus_wr),
    .sel          (sel),
    .bus_wdata    (bus_wdata),
    .bus_rdata    (bus_rdata),
    .ack_valid    (ack_valid),
    .ack_num      (ack_num),
    .level_q      (level_q),
    .pend_q       (pend_q),
    .force_q      (force_q),
    .bcast_q      (bcast_q),
    .mask_q       (mask_q),
    .ext_q        (ext_q),
    .in_pend_set  (in_pend_set),
    .in_force_set (in_force_set),
    .ack_vec      (ack_vec)
  );

  pirq_select #(
    .NLINES (NLINES)
  ) u_select (
    .pend_q    (pend_q),
    .force_q   (force_q),
    .mask_q    (mask_q),
    .level_q   (level_q),
    .eff_vec   (eff_vec),
    .hi_any    (hi_any),
    .irq_req   (irq_req),
    .irq_valid (irq_valid)
  );

endmodule

// File: rtl/pirq_ctrl_chk.sv
module pirq_ctrl_chk
  import pirq_pkg::*;
#(
  parameter int NLINES = 16,
  parameter int DATA_W = 32,
  parameter int EXT_W  = 4,
  localparam int ID_W  = $clog2(NLINES)
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NLINES-1:0] irq_in,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              ack_valid,
  input logic [ID_W-1:0]   ack_num,
  input logic [ID_W-1:0]   irq_req,
  input logic              irq_valid,
  input logic [NLINES-1:0] level_q,
  input logic [NLINES-1:0] pend_q,
  input logic [NLINES-1:0] force_q,
  input logic [NLINES-1:0] bcast_q,
  input logic [NLINES-1:0] mask_q,
  input logic [NLINES-1:0] in_pend_set,
  input logic [NLINES-1:0] in_force_set
);

  logic [NLINES-1:0] c_eff, c_class;

  always_comb begin
    c_eff   = (pend_q | force_q) & mask_q;
    c_class = level_q[irq_req] ? (c_eff & level_q) : (c_eff & ~level_q);
  end

  // R2: reserved bit never held
  p_bit0_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(level_q[0] | pend_q[0] | force_q[0] | bcast_q[0] | mask_q[0]));

  // R3: routed input lands in the pending set on the next edge
  p_input_to_pend_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (|in_pend_set) |=> ((pend_q & $past(in_pend_set)) == $past(in_pend_set)));

  // R3: broadcast input lands in the force set
  p_input_to_force_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (|in_force_set) |=> ((force_q & $past(in_force_set)) == $past(in_force_set)));

  // R7: nothing effective means no request
  p_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (c_eff == '0) |-> (!irq_valid && irq_req == '0));

  // R7: a presented line is effective
  p_req_effective_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> c_eff[irq_req]);

  // R8: high class wins
  p_high_first_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (|(c_eff & level_q)) |-> (irq_valid && level_q[irq_req]));

  // R8: highest number within the class
  p_highest_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> ((c_class >> irq_req) == NLINES'(1)));

  // R9: acknowledge clears pending when no input re-sets it
  p_ack_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_valid && ack_num != '0 && !irq_in[ack_num]) |=> !pend_q[$past(ack_num)]);

  // R11: status offset reads zero
  p_mpstat_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr && bus_addr == OFF_MPSTAT) |-> (bus_rdata == '0));

endmodule

bind pirq_ctrl pirq_ctrl_chk #(
  .NLINES (NLINES),
  .DATA_W (DATA_W),
  .EXT_W  (EXT_W)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .irq_in       (irq_in),
  .bus_sel      (bus_sel),
  .bus_wr       (bus_wr),
  .bus_addr     (bus_addr),
  .bus_rdata    (bus_rdata),
  .ack_valid    (ack_valid),
  .ack_num      (ack_num),
  .irq_req      (irq_req),
  .irq_valid    (irq_valid),
  .level_q      (level_q),
  .pend_q       (pend_q),
  .force_q      (force_q),
  .bcast_q      (bcast_q),
  .mask_q       (mask_q),
  .in_pend_set  (in_pend_set),
  .in_force_set (in_force_set)
);

// File: tb/pirq_ctrl_test.sv
`timescale 1ns/1ps
module pirq_ctrl_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] irq_in;
  logic        bus_sel, bus_wr;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        ack_valid;
  logic [3:0]  ack_num;
  logic [3:0]  irq_req;
  logic        irq_valid;

  int checks = 0;
  int errors = 0;

  // reference state
  logic [15:0] m_level, m_pend, m_force, m_bcast, m_mask;
  logic [3:0]  m_ext;

  always #2.5 clk = ~clk;

  pirq_ctrl uut (
    .clk (clk), .rst_n (rst_n), .irq_in (irq_in),
    .bus_sel (bus_sel), .bus_wr (bus_wr), .bus_addr (bus_addr),
    .bus_wdata (bus_wdata), .bus_rdata (bus_rdata),
    .ack_valid (ack_valid), .ack_num (ack_num),
    .irq_req (irq_req), .irq_valid (irq_valid)
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] m_read(input logic [7:0] a);
    case (a)
      8'h00: return {16'h0, m_level};
      8'h04: return {16'h0, m_pend};
      8'h08: return {16'h0, m_force};
      8'h14: return {16'h0, m_bcast};
      8'h40: return {16'h0, m_mask};
      8'h80: return {16'h0, m_force};
      8'hC0: return {28'h0, m_ext};
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic [3:0] m_req();
    logic [15:0] e, pick;
    logic [3:0]  r;
    e    = (m_pend | m_force) & m_mask;
    pick = ((e & m_level) != 16'h0) ? (e & m_level) : (e & ~m_level);
    r = 4'h0;
    for (int i = 15; i >= 1; i--)
      if (pick[i] && r == 4'h0) r = 4'(i);
    return r;
  endfunction

  task automatic m_update(input logic [15:0] irq, input logic w, input logic [7:0] a,
                          input logic [31:0] d, input logic av, input logic [3:0] an);
    logic [15:0] lo, hi, ackm, np, nf;
    lo   = d[15:0] & 16'hFFFE;
    hi   = d[31:16] & 16'hFFFE;
    ackm = (av && an != 0) ? (16'h1 << an) : 16'h0;
    np = m_pend;
    nf = m_force;
    if (w && a == 8'h0C) np = np & ~lo;
    if (w && a == 8'h08) nf = lo;
    if (w && a == 8'h80) nf = (nf | lo) & ~hi;
    np = (np & ~ackm) | (irq & ~m_bcast & 16'hFFFE);
    nf = (nf & ~ackm) | (irq &  m_bcast & 16'hFFFE);
    if (w && a == 8'h00) m_level = lo;
    if (w && a == 8'h14) m_bcast = lo;
    if (w && a == 8'h40) m_mask  = lo;
    if (w && a == 8'hC0) m_ext   = d[3:0];
    m_pend  = np;
    m_force = nf;
  endtask

  // called at a falling edge; returns at the next falling edge with inputs idle
  task automatic step(input logic [15:0] irq, input logic w, input logic [7:0] a,
                      input logic [31:0] d, input logic av, input logic [3:0] an);
    irq_in = irq; bus_sel = w; bus_wr = w; bus_addr = a; bus_wdata = d;
    ack_valid = av; ack_num = an;
    @(posedge clk);
    #0.5;
    m_update(irq, w, a, d, av, an);
    @(negedge clk);
    irq_in = 16'h0; bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = 8'h0;
    bus_wdata = 32'h0; ack_valid = 1'b0; ack_num = 4'h0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    step(16'h0, 1'b1, a, d, 1'b0, 4'h0);
  endtask

  task automatic rd_chk(input logic [7:0] a, input string tag);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1;
    chk(bus_rdata, m_read(a), tag);
    bus_sel = 1'b0; bus_addr = 8'h0;
  endtask

  task automatic rd_exp(input logic [7:0] a, input logic [31:0] e, input string tag);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1;
    chk(bus_rdata, e, tag);
    bus_sel = 1'b0; bus_addr = 8'h0;
  endtask

  task automatic irq_chk(input string tag);
    chk({28'h0, irq_req}, {28'h0, m_req()}, tag);
    chk({31'h0, irq_valid}, {31'h0, (m_req() != 4'h0)}, tag);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] addrs [12];
    int unsigned seed_set;
    seed_set = $urandom(32'd20240611);
    addrs = '{8'h00, 8'h04, 8'h08, 8'h0C, 8'h10, 8'h14, 8'h40, 8'h80, 8'hC0,
              8'h44, 8'h84, 8'h22};
    m_level = 0; m_pend = 0; m_force = 0; m_bcast = 0; m_mask = 0; m_ext = 0;
    rst_n = 1'b0; irq_in = 0; bus_sel = 0; bus_wr = 0; bus_addr = 0;
    bus_wdata = 0; ack_valid = 0; ack_num = 0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    foreach (addrs[i]) rd_exp(addrs[i], 32'h0, "R1 reset read");
    chk({31'h0, irq_valid}, 32'h0, "R1 reset valid");
    chk({28'h0, irq_req}, 32'h0, "R1 reset req");

    // R2: reserved bit 0 and upper half dropped
    wr(8'h00, 32'hFFFF_FFFF); rd_exp(8'h00, 32'h0000_FFFE, "R2 level");
    wr(8'h14, 32'h0001_0001); rd_exp(8'h14, 32'h0, "R2 bcast");
    wr(8'h40, 32'hFFFF_FFFF); rd_exp(8'h40, 32'h0000_FFFE, "R2 mask");
    wr(8'h00, 32'h0);

    // R3: routing of inputs; bit 0 ignored
    step(16'h0009, 1'b0, 8'h0, 32'h0, 1'b0, 4'h0);
    rd_exp(8'h04, 32'h0000_0008, "R3 pend set");
    rd_exp(8'h80, 32'h0, "R3 force untouched");
    irq_chk("R7 single request");
    wr(8'h14, 32'h0000_0400);
    step(16'h0400, 1'b0, 8'h0, 32'h0, 1'b0, 4'h0);
    rd_exp(8'h80, 32'h0000_0400, "R3 broadcast to force");
    rd_exp(8'h04, 32'h0000_0008, "R3 pend unchanged");
    chk({28'h0, irq_req}, 32'd10, "R8 highest low class");

    // R4: clear register
    step(16'h00F0, 1'b0, 8'h0, 32'h0, 1'b0, 4'h0);
    wr(8'h0C, 32'h0000_0031);
    rd_exp(8'h04, 32'h0000_00C8, "R4 partial clear");
    rd_exp(8'h0C, 32'h0, "R4 clear reads zero");
    wr(8'h0C, 32'hFFFF_FFFF);
    rd_exp(8'h04, 32'h0, "R4 full clear");

    // R5: set/clear halves of force
    wr(8'h80, 32'h0000_0006);
    rd_exp(8'h80, 32'h0000_0406, "R5 set half");
    wr(8'h80, 32'h0400_0010);
    rd_exp(8'h80, 32'h0000_0016, "R5 set and clear");
    wr(8'h80, 32'h0020_0020);
    rd_exp(8'h80, 32'h0000_0016, "R5 same bit ends clear");

    // R6: alias replaces force
    wr(8'h08, 32'h0000_0003);
    rd_exp(8'h08, 32'h0000_0002, "R6 alias replace");
    rd_exp(8'h80, 32'h0000_0002, "R6 alias shared");
    wr(8'h08, 32'h0);

    // R8: class priority
    wr(8'h00, 32'h0000_0002);
    step(16'h4002, 1'b0, 8'h0, 32'h0, 1'b0, 4'h0);
    chk({28'h0, irq_req}, 32'd1, "R8 high class over number");
    wr(8'h40, 32'h0000_FFFC);
    chk({28'h0, irq_req}, 32'd14, "R8 masked high falls to low");

    // R9: acknowledge
    step(16'h0, 1'b0, 8'h0, 32'h0, 1'b1, 4'd14);
    rd_exp(8'h04, 32'h0000_0002, "R9 ack clears pending");
    wr(8'h80, 32'h0000_0100);
    step(16'h0, 1'b0, 8'h0, 32'h0, 1'b1, 4'd8);
    rd_exp(8'h80, 32'h0, "R9 ack clears force");
    step(16'h0, 1'b0, 8'h0, 32'h0, 1'b1, 4'd0);
    rd_exp(8'h04, 32'h0000_0002, "R9 ack zero no effect");

    // R10: set beats ack and clear
    step(16'h0020, 1'b0, 8'h0, 32'h0, 1'b1, 4'd5);
    rd_exp(8'h04, 32'h0000_0022, "R10 set over ack");
    step(16'h0020, 1'b1, 8'h0C, 32'h0000_0020, 1'b1, 4'd5);
    rd_exp(8'h04, 32'h0000_0022, "R10 set over clear");

    // R11: status and extended
    wr(8'h10, 32'hFFFF_FFFF);
    rd_exp(8'h10, 32'h0, "R11 status zero");
    wr(8'hC0, 32'h0000_00FF);
    rd_exp(8'hC0, 32'h0000_000F, "R11 extended low bits");

    // R12: unmapped offsets
    wr(8'h44, 32'hFFFF_FFFF); rd_exp(8'h44, 32'h0, "R12 other cpu mask");
    rd_exp(8'h40, 32'h0000_FFFC, "R12 mask untouched");
    wr(8'h84, 32'h0000_FFFF); rd_exp(8'h80, 32'h0, "R12 force untouched");
    wr(8'h01, 32'hFFFF_FFFF); rd_exp(8'h00, 32'h0000_0002, "R12 misaligned write");
    rd_exp(8'h05, 32'h0, "R12 misaligned read");
    rd_exp(8'h20, 32'h0, "R12 gap read");

    // R7: all masked
    wr(8'h40, 32'h0);
    irq_chk("R7 masked idle");
    chk({31'h0, irq_valid}, 32'h0, "R7 masked valid low");

    // R13: random traffic against the model
    for (int n = 0; n < 600; n++) begin
      logic [15:0] ri;
      logic        w, av;
      logic [7:0]  a;
      logic [31:0] d;
      ri = 16'($urandom) & 16'($urandom) & 16'($urandom);
      w  = ($urandom % 2) == 0;
      a  = addrs[$urandom % 12];
      d  = $urandom;
      if (a == 8'h14) d = d & 32'h0000_0F0F;
      av = ($urandom % 3) == 0;
      step(ri, w, a, d, av, 4'($urandom));
      irq_chk("R13 random request");
      rd_chk(addrs[$urandom % 12], "R13 random read");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule